// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the pin interface of a 16-bit-wide parallel NOR flash. Each clock it may receive one sampled host write, made of a word address and a data word. From the stream of writes it recognises the standard unlock-and-command handshakes. When a sequence completes, it raises a one-cycle request toward the array engine for one of six operations: word program, sector erase, block erase, chip erase, erase suspend or erase resume.

The block also holds the read mode that the output path uses to choose what a read returns. The mode is normal array data, query (CFI) data or security-ID data. Only the low byte of the data word is decoded. Only the low address bits are matched against the unlock addresses 555h and 2AAh.

Two inputs can block the decoder. While the array engine reports busy, every write is dropped and the decoder keeps its state. While the write-protect input is low, chip erase is refused, and so is any program or erase whose target lies in the 8 KWord boot block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, read_mode is 0 (array read), no request is raised, and no sequence is in progress.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h and then any address and data produce req_program on the cycle after the fourth write. tgt_addr and tgt_data hold that fourth write's address and data.
- R3: The five-write prefix AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, followed by 50h at any address, raises req_sector_erase. tgt_addr equals that sixth address.
- R4: The same prefix followed by 30h at any address raises req_block_erase.
- R5: The same prefix followed by 10h@555h raises req_chip_erase.
- R6: Query mode is entered by AAh@555h, 55h@2AAh, 98h@555h. It is also entered by a single write of 89h with address low bits equal to 055h. In query mode read_mode is 1.
- R7: The writes AAh@555h, 55h@2AAh, 88h@555h set read_mode to 2 (security ID).
- R8: When no sequence is in progress, a single write of B0h at any address raises req_suspend, and a single write of 30h at any address raises req_resume.
- R9: A write of F0h at any address returns read_mode to 0.
- R10: A write that does not fit the sequence in progress sets read_mode to 0 and discards the partial sequence.
- R11: While busy is high, writes change neither the sequence state nor read_mode and raise no request. This includes F0h.
- R12: While wp_n is low, chip erase is dropped. Program, sector erase and block erase are also dropped when address bits above bit 12 are all zero (the boot block with BOOT_AT_TOP=0). Targets outside the boot block proceed.
- R13: Data bits 15 to 8 are ignored in every command write.
- R14: Each request is high for exactly one cycle, and at most one request is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A host write is present this cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| busy | input | 1 | Array engine is running an operation |
| wp_n | input | 1 | Write-protect, low protects the boot block |
| req_program | output | 1 | Word program request pulse |
| req_sector_erase | output | 1 | Sector erase request pulse |
| req_block_erase | output | 1 | Block erase request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| tgt_addr | output | ADDR_W | Address captured with the last request |
| tgt_data | output | 16 | Data captured with the last program request |
| read_mode | output | 2 | 0 array, 1 query, 2 security ID |

## Verification
The bench checks that 30h is decoded differently depending on the sequence in progress. A decoder that confuses the two meanings would raise resume at the end of a block-erase sequence, or block erase from an idle single write. It also breaks a sequence midway and then replays only its tail. A decoder that keeps stale unlock progress would then issue a program request with no unlock. Busy is asserted in the middle of a sequence: a design that resets or advances the sequence under busy either loses the command or obeys the junk write. The bench also sends erases just inside and just outside the boot block with write-protect low, so a wrong boundary either erases protected words or refuses legal ones.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W      = 19,
  parameter int MATCH_W     = 11,
  parameter int BOOT_W      = 13,
  parameter bit BOOT_AT_TOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              busy,
  input  logic              wp_n,
  output logic              req_program,
  output logic              req_sector_erase,
  output logic              req_block_erase,
  output logic              req_chip_erase,
  output logic              req_suspend,
  output logic              req_resume,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [15:0]       tgt_data,
  output logic [1:0]        read_mode
);

  localparam logic [MATCH_W-1:0] A_UNLOCK1 = MATCH_W'('h555);
  localparam logic [MATCH_W-1:0] A_UNLOCK2 = MATCH_W'('h2AA);
  localparam logic [MATCH_W-1:0] A_QSHORT  = MATCH_W'('h055);
  localparam logic [1:0] M_ARRAY = 2'd0;
  localparam logic [1:0] M_QUERY = 2'd1;
  localparam logic [1:0] M_SECID = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_E3, S_E4, S_E5} seq_t;
  seq_t state;

  logic [7:0]         cmd;
  logic [MATCH_W-1:0] alo;
  logic               at1, at2, boot_hit, guard, take;

  assign cmd      = wr_data[7:0];
  assign alo      = wr_addr[MATCH_W-1:0];
  assign at1      = (alo == A_UNLOCK1);
  assign at2      = (alo == A_UNLOCK2);
  assign boot_hit = BOOT_AT_TOP ? (&wr_addr[ADDR_W-1:BOOT_W]) : ~(|wr_addr[ADDR_W-1:BOOT_W]);
  assign guard    = !wp_n && boot_hit;
  assign take     = wr_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state            <= S_IDLE;
      read_mode        <= M_ARRAY;
      req_program      <= 1'b0;
      req_sector_erase <= 1'b0;
      req_block_erase  <= 1'b0;
      req_chip_erase   <= 1'b0;
      req_suspend      <= 1'b0;
      req_resume       <= 1'b0;
      tgt_addr         <= '0;
      tgt_data         <= '0;
    end else begin
      req_program      <= 1'b0;
      req_sector_erase <= 1'b0;
      req_block_erase  <= 1'b0;
      req_chip_erase   <= 1'b0;
      req_suspend      <= 1'b0;
      req_resume       <= 1'b0;
      if (take) begin
        state <= S_IDLE;
        case (state)
          S_IDLE: begin
            if (cmd == 8'hAA && at1)            state <= S_U1;
            else if (cmd == 8'hB0)              begin req_suspend <= 1'b1; tgt_addr <= wr_addr; end
            else if (cmd == 8'h30)              begin req_resume  <= 1'b1; tgt_addr <= wr_addr; end
            else if (cmd == 8'h89 && alo == A_QSHORT) read_mode <= M_QUERY;
            else                                read_mode <= M_ARRAY;
          end
          S_U1: begin
            if (cmd == 8'h55 && at2) state <= S_U2;
            else                     read_mode <= M_ARRAY;
          end
          S_U2: begin
            if (at1 && cmd == 8'hA0)      state <= S_PGM;
            else if (at1 && cmd == 8'h80) state <= S_E3;
            else if (at1 && cmd == 8'h98) read_mode <= M_QUERY;
            else if (at1 && cmd == 8'h88) read_mode <= M_SECID;
            else                          read_mode <= M_ARRAY;
          end
          S_PGM: begin
            req_program <= !guard;
            tgt_addr    <= wr_addr;
            tgt_data    <= wr_data;
          end
          S_E3: begin
            if (cmd == 8'hAA && at1) state <= S_E4;
            else                     read_mode <= M_ARRAY;
          end
          S_E4: begin
            if (cmd == 8'h55 && at2) state <= S_E5;
            else                     read_mode <= M_ARRAY;
          end
          S_E5: begin
            tgt_addr <= wr_addr;
            if (cmd == 8'h50)             req_sector_erase <= !guard;
            else if (cmd == 8'h30)        req_block_erase  <= !guard;
            else if (cmd == 8'h10 && at1) req_chip_erase   <= wp_n;
            else                          read_mode <= M_ARRAY;
          end
          default: read_mode <= M_ARRAY;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W      = 19,
  parameter int BOOT_W      = 13,
  parameter bit BOOT_AT_TOP = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_data,
  input logic              busy,
  input logic              wp_n,
  input logic              req_program,
  input logic              req_sector_erase,
  input logic              req_block_erase,
  input logic              req_chip_erase,
  input logic              req_suspend,
  input logic              req_resume,
  input logic [1:0]        read_mode
);

  logic [5:0] reqs;
  logic       in_boot;
  assign reqs = {req_program, req_sector_erase, req_block_erase,
                 req_chip_erase, req_suspend, req_resume};
  assign in_boot = BOOT_AT_TOP ? (wr_addr[ADDR_W-1:BOOT_W] == '1)
                               : (wr_addr[ADDR_W-1:BOOT_W] == '0);

  a_r14_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(reqs));
  a_r14_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (reqs != 6'd0) |=> (reqs != $past(reqs)) || (reqs == 6'd0));
  a_r11_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (reqs == 6'd0) && $stable(read_mode));
  a_r10_idle_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(read_mode));
  a_r9_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !busy && wr_data[7:0] == 8'hF0) |=> (read_mode == 2'd0));
  a_r12_chip_wp: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> !req_chip_erase);
  a_r12_boot_wp: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && in_boot) |=> !(req_program || req_sector_erase || req_block_erase));
  a_r1_mode_range: assert property (@(posedge clk) disable iff (!rst_n)
    read_mode != 2'd3);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .BOOT_AT_TOP(BOOT_AT_TOP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .wp_n(wp_n),
  .req_program(req_program), .req_sector_erase(req_sector_erase),
  .req_block_erase(req_block_erase), .req_chip_erase(req_chip_erase),
  .req_suspend(req_suspend), .req_resume(req_resume), .read_mode(read_mode)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          busy = 1'b0;
  logic          wp_n = 1'b1;
  logic req_program, req_sector_erase, req_block_erase, req_chip_erase, req_suspend, req_resume;
  logic [AW-1:0] tgt_addr;
  logic [15:0]   tgt_data;
  logic [1:0]    read_mode;

  int checks = 0;
  int failures = 0;
  logic [5:0]    got_req;
  logic [1:0]    got_mode;
  logic [AW-1:0] got_addr;
  logic [15:0]   got_data;

  always #10 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .wp_n(wp_n),
    .req_program(req_program), .req_sector_erase(req_sector_erase),
    .req_block_erase(req_block_erase), .req_chip_erase(req_chip_erase),
    .req_suspend(req_suspend), .req_resume(req_resume),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .read_mode(read_mode)
  );

  // request bits: {program, sector, block, chip, suspend, resume}
  localparam logic [5:0] P = 6'b100000, SE = 6'b010000, BE = 6'b001000;
  localparam logic [5:0] CE = 6'b000100, SU = 6'b000010, RE = 6'b000001, NO = 6'b000000;
  localparam int NV = 34;
  // {addr, data, exp_req, exp_mode}
  localparam logic [AW+16+6+2-1:0] VEC [NV] = '{
    {19'h00555, 16'h00AA, NO, 2'd0}, {19'h002AA, 16'h0055, NO, 2'd0},
    {19'h00555, 16'h00A0, NO, 2'd0}, {19'h40000, 16'h1234, P,  2'd0},
    {19'h00555, 16'h12AA, NO, 2'd0}, {19'h002AA, 16'h0055, NO, 2'd0},
    {19'h00555, 16'h0080, NO, 2'd0}, {19'h00555, 16'h00AA, NO, 2'd0},
    {19'h002AA, 16'hFF55, NO, 2'd0}, {19'h0C800, 16'h0050, SE, 2'd0},
    {19'h00555, 16'h00AA, NO, 2'd0}, {19'h002AA, 16'h0055, NO, 2'd0},
    {19'h00555, 16'h0080, NO, 2'd0}, {19'h00555, 16'h00AA, NO, 2'd0},
    {19'h002AA, 16'h0055, NO, 2'd0}, {19'h30000, 16'h0030, BE, 2'd0},
    {19'h00555, 16'h00AA, NO, 2'd0}, {19'h002AA, 16'h0055, NO, 2'd0},
    {19'h00555, 16'h0080, NO, 2'd0}, {19'h00555, 16'h00AA, NO, 2'd0},
    {19'h002AA, 16'h0055, NO, 2'd0}, {19'h00555, 16'h0010, CE, 2'd0},
    {19'h07123, 16'h55B0, SU, 2'd0}, {19'h00010, 16'h0030, RE, 2'd0},
    {19'h00055, 16'h0089, NO, 2'd1}, {19'h00000, 16'h00F0, NO, 2'd0},
    {19'h00555, 16'h00AA, NO, 2'd0}, {19'h002AA, 16'h0055, NO, 2'd0},
    {19'h00555, 16'h0098, NO, 2'd1}, {19'h12345, 16'hABF0, NO, 2'd0},
    {19'h00555, 16'h00AA, NO, 2'd0}, {19'h002AA, 16'h0055, NO, 2'd0},
    {19'h00555, 16'h0088, NO, 2'd2}, {19'h00001, 16'h00F0, NO, 2'd0}
  };

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic b, input logic w);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; busy = b; wp_n = w;
    @(negedge clk);
    got_req  = {req_program, req_sector_erase, req_block_erase, req_chip_erase, req_suspend, req_resume};
    got_mode = read_mode; got_addr = tgt_addr; got_data = tgt_data;
    wr_valid = 1'b0; busy = 1'b0; wp_n = 1'b1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic erase6(input logic [AW-1:0] a, input logic [15:0] c, input logic w);
    wr(19'h00555, 16'h00AA, 1'b0, w); wr(19'h002AA, 16'h0055, 1'b0, w);
    wr(19'h00555, 16'h0080, 1'b0, w); wr(19'h00555, 16'h00AA, 1'b0, w);
    wr(19'h002AA, 16'h0055, 1'b0, w); wr(a, c, 1'b0, w);
  endtask

  task automatic prog4(input logic [AW-1:0] a, input logic [15:0] d, input logic w);
    wr(19'h00555, 16'h00AA, 1'b0, w); wr(19'h002AA, 16'h0055, 1'b0, w);
    wr(19'h00555, 16'h00A0, 1'b0, w); wr(a, d, 1'b0, w);
  endtask

  initial begin
    #3000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode after reset", 32'(read_mode), 0);
    chk("R1 requests after reset", 32'({req_program, req_sector_erase, req_block_erase,
        req_chip_erase, req_suspend, req_resume}), 0);
    rst_n = 1'b1;

    // table: R2 R3 R4 R5 R6 R7 R8 R9 R13
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][AW+23:24], VEC[i][23:8], 1'b0, 1'b1);
      chk($sformatf("R2-R9/R13 vec %0d req", i), 32'(got_req), 32'(VEC[i][7:2]));
      chk($sformatf("R6/R7/R9 vec %0d mode", i), 32'(got_mode), 32'(VEC[i][1:0]));
    end

    // R2 target capture and R14 width
    prog4(19'h2ABCD, 16'hBEEF, 1'b1);
    chk("R2 program pulse", 32'(got_req), 32'(P));
    chk("R2 tgt_addr", 32'(got_addr), 32'h2ABCD);
    chk("R2 tgt_data", 32'(got_data), 32'hBEEF);
    @(negedge clk);
    chk("R14 pulse drops", 32'(req_program), 0);

    // R3 sector address capture
    erase6(19'h3F800, 16'h0050, 1'b1);
    chk("R3 sector pulse", 32'(got_req), 32'(SE));
    chk("R3 sector tgt_addr", 32'(got_addr), 32'h3F800);

    // R10 broken sequence clears progress and mode
    wr(19'h00055, 16'h0089, 1'b0, 1'b1);
    chk("R6 query shortcut", 32'(got_mode), 1);
    wr(19'h00555, 16'h00AA, 1'b0, 1'b1);
    wr(19'h002AA, 16'h0077, 1'b0, 1'b1);
    chk("R10 mode back to array", 32'(got_mode), 0);
    wr(19'h002AA, 16'h0055, 1'b0, 1'b1);
    wr(19'h00555, 16'h00A0, 1'b0, 1'b1);
    wr(19'h00100, 16'h1111, 1'b0, 1'b1);
    chk("R10 stale tail gives no program", 32'(got_req), 0);

    // R11 busy
    wr(19'h00055, 16'h0089, 1'b0, 1'b1);
    wr(19'h00000, 16'h00F0, 1'b1, 1'b1);
    chk("R11 exit ignored when busy", 32'(got_mode), 1);
    wr(19'h00000, 16'h00B0, 1'b1, 1'b1);
    chk("R11 suspend ignored when busy", 32'(got_req), 0);
    wr(19'h00000, 16'h00F0, 1'b0, 1'b1);
    wr(19'h00555, 16'h00AA, 1'b0, 1'b1);
    wr(19'h002AA, 16'h0055, 1'b0, 1'b1);
    wr(19'h00000, 16'h0077, 1'b1, 1'b1);
    wr(19'h00555, 16'h00A0, 1'b0, 1'b1);
    wr(19'h05000, 16'h4242, 1'b0, 1'b1);
    chk("R11 sequence held across busy", 32'(got_req), 32'(P));

    // R12 write protect
    erase6(19'h00555, 16'h0010, 1'b0);
    chk("R12 chip erase refused", 32'(got_req), 0);
    erase6(19'h01800, 16'h0050, 1'b0);
    chk("R12 boot sector refused", 32'(got_req), 0);
    erase6(19'h02000, 16'h0050, 1'b0);
    chk("R12 sector past boot allowed", 32'(got_req), 32'(SE));
    erase6(19'h00000, 16'h0030, 1'b0);
    chk("R12 boot block refused", 32'(got_req), 0);
    prog4(19'h01000, 16'h0000, 1'b0);
    chk("R12 boot program refused", 32'(got_req), 0);
    erase6(19'h01800, 16'h0050, 1'b1);
    chk("R12 boot sector with wp_n high", 32'(got_req), 32'(SE));
    erase6(19'h00555, 16'h0010, 1'b1);
    chk("R5 chip erase with wp_n high", 32'(got_req), 32'(CE));

    // R8 30h in idle is resume, not block erase
    wr(19'h00000, 16'h0030, 1'b0, 1'b1);
    chk("R8 idle 30h is resume", 32'(got_req), 32'(RE));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule